// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the address sequence for a four-beat burst on a synchronous memory. A burst begins when either of two start strobes is high at a clock edge. The external address is captured at that edge, and the beat index goes back to zero. On each later cycle where the advance input is high and neither strobe is high, the beat index steps by one. Only the two lowest address bits follow the beat. The upper bits keep the captured value, and the two-bit beat index wraps without any carry into them.

An order input picks one of two ways to combine the captured low bits with the beat index: exclusive-or (interleaved order) or addition modulo four (linear order). Any strobe reloads the address straight away, so a burst can be dropped at any beat with no lost cycle. The parameter `USE_ORDER_INPUT` stands in for a board that leaves the order pin unconnected. At its value 0 the order input is ignored and interleaved order applies. The memory array, the write controls and the read data path belong to other blocks.

Top module: `burst_seq_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next outputs are `burst_addr` = 0 and `beat` = 0.
- R2: When `start_a`, `start_b` or both are high at an edge, the next cycle shows `burst_addr` equal to the `ext_addr` sampled at that edge, with `beat` = 0. Both strobes together count as one start.
- R3: When `adv` is high and both strobes are low at an edge, `beat` becomes the previous value plus one modulo 4 (3 wraps to 0).
- R4: When `adv` and both strobes are low at an edge, `beat` and `burst_addr` keep their values (order input unchanged).
- R5: With `order_lin` = 0, `burst_addr[1:0]` equals the captured low bits XOR `beat`.
- R6: With `order_lin` = 1, `burst_addr[1:0]` equals the captured low bits plus `beat`, modulo 4.
- R7: Between starts, `burst_addr[ADDR_W-1:2]` keeps the captured upper bits, including when the low bits wrap from 3 to 0 in linear order.
- R8: A strobe takes priority over `adv` at any beat: the burst restarts from the new address with `beat` = 0.
- R9: With `USE_ORDER_INPUT` = 0, `order_lin` has no effect and the low bits always follow R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_addr | input | ADDR_W | External start address |
| start_a | input | 1 | First burst-start strobe, active high |
| start_b | input | 1 | Second burst-start strobe, active high |
| adv | input | 1 | Advance to the next beat, active high |
| order_lin | input | 1 | 1 = linear order, 0 = interleaved order |
| burst_addr | output | ADDR_W | Current array address |
| beat | output | 2 | Beat index within the burst |

## Verification
The bench builds two copies with `ADDR_W` = 12, one with `USE_ORDER_INPUT` = 1 and one with 0. Both copies receive the same stimulus, so in every cycle that has linear order selected, the fixed copy must keep producing interleaved addresses while the other copy switches. A narrow address allows directed start addresses whose low bits are 3 and whose upper bits are all ones. With those, a wrong carry out of the beat logic shows up on the upper bits. A long stretch of random strobes, advances and order changes then reaches every start offset, every restart beat, and both strobes firing together.

// File: rtl/burst_seq_gen_pkg.sv
// Package: shared constants and the order encoding for the burst generator.
// Assumes the burst length is fixed at four beats.
package burst_seq_gen_pkg;
    localparam int BEAT_W = 2;

    typedef enum logic {
        ORD_INTERLEAVE = 1'b0,
        ORD_LINEAR     = 1'b1
    } order_e;
endpackage

// File: rtl/bsg_start_capture.sv
// Start capture: holds the address sampled when a burst starts.
// Assumes load is already the OR of all start strobes.
module bsg_start_capture #(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] base_addr
);
    // Capture the external address on a start; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_addr <= '0;
        else if (load)
            base_addr <= ext_addr;
    end
endmodule

// File: rtl/bsg_beat_counter.sv
// Beat counter: wrapping index of the current beat inside a burst.
// Assumes load takes priority over adv; wraps with no carry out.
module bsg_beat_counter
    import burst_seq_gen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv,
    output logic [BEAT_W-1:0] beat
);
    // Clear on reset or start, step on advance, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            beat <= '0;
        else if (load)
            beat <= '0;
        else if (adv)
            beat <= beat + BEAT_W'(1);
    end
endmodule

// File: rtl/bsg_order_map.sv
// Order map: combines captured low address bits with the beat index.
// Assumes order_lin is static within a burst; with USE_ORDER_INPUT = 0
// the input is ignored and interleaved order is forced.
module bsg_order_map
    import burst_seq_gen_pkg::*;
#(
    parameter bit USE_ORDER_INPUT = 1'b1
) (
    input  logic [BEAT_W-1:0] base_low,
    input  logic [BEAT_W-1:0] beat,
    input  logic              order_lin,
    output logic [BEAT_W-1:0] addr_low
);
    order_e order;

    generate
        if (USE_ORDER_INPUT) begin : g_pin_order
            // Take the order from the input pin.
            always_comb order = order_e'(order_lin);
        end else begin : g_fixed_order
            logic unused_order_lin;
            // Pin treated as unconnected: interleaved order only.
            always_comb begin
                unused_order_lin = order_lin;
                order            = ORD_INTERLEAVE;
            end
        end
    endgenerate

    // Pick XOR or modulo-4 sum of start offset and beat.
    always_comb begin
        if (order == ORD_LINEAR)
            addr_low = base_low + beat;
        else
            addr_low = base_low ^ beat;
    end
endmodule

// File: rtl/burst_seq_gen.sv
// Burst address sequence generator top.
// Starts a four-beat burst on either strobe, steps the two low address
// bits on adv, maps them by the selected order. Upper bits never change
// inside a burst. Assumes ADDR_W >= 3.
module burst_seq_gen
    import burst_seq_gen_pkg::*;
#(
    parameter int ADDR_W          = 17,
    parameter bit USE_ORDER_INPUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              start_a,
    input  logic              start_b,
    input  logic              adv,
    input  logic              order_lin,
    output logic [ADDR_W-1:0] burst_addr,
    output logic [BEAT_W-1:0] beat
);
    localparam int UPPER_W = ADDR_W - BEAT_W;

    logic              load;
    logic [ADDR_W-1:0] base_addr;
    logic [BEAT_W-1:0] addr_low;

    // Either strobe, or both together, is one start.
    always_comb load = start_a | start_b;

    bsg_start_capture #(.ADDR_W(ADDR_W)) cap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .ext_addr (ext_addr),
        .base_addr(base_addr)
    );

    bsg_beat_counter cnt_i (
        .clk  (clk),
        .rst_n(rst_n),
        .load (load),
        .adv  (adv),
        .beat (beat)
    );

    bsg_order_map #(.USE_ORDER_INPUT(USE_ORDER_INPUT)) map_i (
        .base_low (base_addr[BEAT_W-1:0]),
        .beat     (beat),
        .order_lin(order_lin),
        .addr_low (addr_low)
    );

    // Join fixed upper bits with the mapped low bits.
    always_comb burst_addr = {base_addr[ADDR_W-1 -: UPPER_W], addr_low};
endmodule

// File: rtl/burst_seq_gen_chk.sv
// Checker: temporal properties of the burst generator, seen at its ports.
// Assumes synchronous active-low reset; all properties are off while in reset.
module burst_seq_gen_chk #(
    parameter int ADDR_W          = 17,
    parameter bit USE_ORDER_INPUT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              start_a,
    input logic              start_b,
    input logic              adv,
    input logic              order_lin,
    input logic [ADDR_W-1:0] burst_addr,
    input logic [1:0]        beat
);
    logic go;
    logic lin_eff;
    // Derived views of the strobes and the effective order.
    always_comb begin
        go      = start_a | start_b;
        lin_eff = USE_ORDER_INPUT ? order_lin : 1'b0;
    end

    // R2 R8
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (burst_addr == $past(ext_addr)) && (beat == 2'd0));

    // R3
    beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!go && adv) |=> beat == $past(beat) + 2'd1);

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!go && !adv) |=> $stable(beat) &&
            ((order_lin != $past(order_lin)) || $stable(burst_addr)));

    // R7
    upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> burst_addr[ADDR_W-1:2] == $past(burst_addr[ADDR_W-1:2]));

    // R5 R9
    interleave_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!go && adv && !lin_eff) |=> lin_eff ||
            ((burst_addr[1:0] ^ $past(burst_addr[1:0])) == (beat ^ $past(beat))));

    // R6
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!go && adv && lin_eff) |=> !lin_eff ||
            (burst_addr[1:0] == $past(burst_addr[1:0]) + 2'd1));
endmodule

bind burst_seq_gen burst_seq_gen_chk #(
    .ADDR_W         (ADDR_W),
    .USE_ORDER_INPUT(USE_ORDER_INPUT)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_addr  (ext_addr),
    .start_a   (start_a),
    .start_b   (start_b),
    .adv       (adv),
    .order_lin (order_lin),
    .burst_addr(burst_addr),
    .beat      (beat)
);

// File: tb/burst_seq_gen_tb_top.sv
`timescale 1ns/1ps
// Bench: two generator copies (order pin used / ignored) against a
// behavioural model, compared on every clock at the falling edge.
module burst_seq_gen_tb_top;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic          start_a = 1'b0, start_b = 1'b0, adv = 1'b0, order_lin = 1'b0;
    logic [AW-1:0] addr_p, addr_f;
    logic [1:0]    beat_p, beat_f;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int m_base = 0;
    int m_cnt  = 0;

    always #2 clk = ~clk;

    burst_seq_gen #(.ADDR_W(AW), .USE_ORDER_INPUT(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .start_a(start_a),
        .start_b(start_b), .adv(adv), .order_lin(order_lin),
        .burst_addr(addr_p), .beat(beat_p));

    burst_seq_gen #(.ADDR_W(AW), .USE_ORDER_INPUT(1'b0)) dut_fix_i (
        .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .start_a(start_a),
        .start_b(start_b), .adv(adv), .order_lin(order_lin),
        .burst_addr(addr_f), .beat(beat_f));

    function automatic int expect_addr(int base, int cnt, bit lin);
        int low;
        low = lin ? ((base + cnt) % 4) : ((base % 4) ^ cnt);
        return (base / 4) * 4 + low;
    endfunction

    task automatic check(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Starts at a falling edge: drive, clock, update model, compare.
    task automatic cyc(input int a, input bit sa, input bit sb, input bit ad,
                       input bit ln, input string tag);
        ext_addr  = AW'(a);
        start_a   = sa;
        start_b   = sb;
        adv       = ad;
        order_lin = ln;
        @(posedge clk);
        if (!rst_n) begin
            m_base = 0; m_cnt = 0;
        end else if (sa || sb) begin
            m_base = a % (1 << AW); m_cnt = 0;
        end else if (ad) begin
            m_cnt = (m_cnt + 1) % 4;
        end
        @(negedge clk);
        check(tag, int'(addr_p), expect_addr(m_base, m_cnt, ln), "pin-order addr");
        check(tag, int'(beat_p), m_cnt, "pin-order beat");
        check("R9", int'(addr_f), expect_addr(m_base, m_cnt, 1'b0), "fixed-order addr");
        check("R9", int'(beat_f), m_cnt, "fixed-order beat");
    endtask

    initial begin
        @(negedge clk);
        // R1: reset wins over strobes and advance
        for (int i = 0; i < 3; i++) cyc(12'h5a7, 1'b1, 1'b0, 1'b1, 1'b0, "R1");
        rst_n = 1'b1;
        // R2 R5 R3 R7: interleaved burst from low bits 2 via start_a, wrap past beat 3
        cyc(12'hffe, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
        for (int i = 0; i < 5; i++) cyc(12'h000, 1'b0, 1'b0, 1'b1, 1'b0, "R5");
        // R4: hold with no advance
        for (int i = 0; i < 3; i++) cyc(12'h123, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
        // R2 R6 R7: linear burst from low bits 3 via start_b, upper bits all ones
        cyc(12'hfff, 1'b0, 1'b1, 1'b0, 1'b1, "R2");
        for (int i = 0; i < 4; i++) cyc(12'h000, 1'b0, 1'b0, 1'b1, 1'b1, "R6");
        cyc(12'h000, 1'b0, 1'b0, 1'b1, 1'b1, "R7");
        cyc(12'h000, 1'b0, 1'b0, 1'b0, 1'b1, "R4");
        // R8: both strobes with advance at beat 2 restarts at beat 0
        cyc(12'h441, 1'b1, 1'b0, 1'b0, 1'b1, "R2");
        cyc(12'h000, 1'b0, 1'b0, 1'b1, 1'b1, "R3");
        cyc(12'h000, 1'b0, 1'b0, 1'b1, 1'b1, "R3");
        cyc(12'h8b3, 1'b1, 1'b1, 1'b1, 1'b1, "R8");
        cyc(12'h000, 1'b0, 1'b0, 1'b1, 1'b0, "R5");
        // Random mix of all controls
        for (int i = 0; i < 600; i++) begin
            bit ln;
            ln = ($urandom % 8) < 4;
            cyc(int'($urandom % 4096), ($urandom % 5) == 0, ($urandom % 5) == 0,
                ($urandom % 3) != 0, ln, ln ? "R6" : "R5");
        end
        // R1: reset in mid-burst
        rst_n = 1'b0;
        cyc(12'h3c2, 1'b0, 1'b0, 1'b1, 1'b1, "R1");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule